// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits between a set of interrupt sources and an instruction fetch unit. It takes one non-maskable reset request and a parameterized number of interrupt lines (eight by default). Each interrupt line has its own enable bit, and one global enable gates all of them. A single-cycle pulse on a request line is captured into a pending latch. The pending bit stays set until that source is taken, so a request that arrives while it is masked is not lost.

When no vector is outstanding, the controller picks the winning request. The reset request wins over everything and is never masked. Among the interrupt lines, those that are pending, individually enabled and allowed by the global enable compete, and the lowest index wins. The controller registers the vector address of the winner and presents it to the fetch unit with a valid flag, which it holds until the fetch unit acknowledges.

Taking any request clears the global enable, so the controller masks itself while a handler runs. A return strobe from the core sets the global enable again. Software can also write the global enable directly.

Top module: `vpic_top`

## Requirements
- R1: After a synchronous reset, `vec_valid` is 0 and `gie` is 0, and every pending latch is empty.
- R2: The reset request is presented as vector address 0. Interrupt line k (k = 0 to NUM_SRC-1) is presented as vector address k+1. `vec_addr` is an unsigned binary number.
- R3: When several eligible requests are pending at once, they are presented one per acknowledge, in ascending vector address order.
- R4: An interrupt line is never taken while its `irq_en` bit is 0 or while `gie` is 0.
- R5: A pending reset request is taken whatever the values of `gie` and `irq_en`, and it outranks every pending interrupt line.
- R6: In the cycle in which `vec_valid` first rises, `gie` already reads 0.
- R7: A `ret_strobe` pulse sets `gie` to 1 at the next clock edge. A `gie_wr` pulse loads `gie_wdata` at the next clock edge and takes precedence over `ret_strobe`. Taking a request takes precedence over both.
- R8: A request pulse that arrives while masked stays pending and is taken once its enable and `gie` allow it.
- R9: While `vec_valid` is 1 and `vec_ack` is 0, `vec_valid` and `vec_addr` stay unchanged. After a clock edge at which `vec_valid` and `vec_ack` are both 1, `vec_valid` is 0.
- R10: If an interrupt line is pulsed for one cycle while it is eligible and the controller is idle, `vec_valid` rises at the second clock edge after the pulse begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_req | input | 1 | Non-maskable reset request pulse (vector 0) |
| irq_req | input | NUM_SRC | Interrupt request pulses; bit k maps to vector k+1 |
| irq_en | input | NUM_SRC | Per-line enable bits |
| gie_wr | input | 1 | Write strobe for the global enable |
| gie_wdata | input | 1 | Value written to the global enable |
| ret_strobe | input | 1 | Return-from-handler strobe; sets the global enable |
| vec_ack | input | 1 | Fetch unit acknowledge of the presented vector |
| vec_valid | output | 1 | A vector address is being presented |
| vec_addr | output | VEC_W | Presented vector address |
| gie | output | 1 | Current global interrupt enable |

## Verification
Every fault inside the controller reaches a port within a few cycles. A pending latch that drops a bit shows up as a vector that never comes. A wrong order in the priority chain shows up as a vector out of sequence on the very next acknowledge. A stuck global enable shows up either as a vector presented while masked, or as `gie` still reading 1 in the cycle a vector rises. A faulty output register shows up as an address that changes, or a valid flag that stays high, within one cycle of the acknowledge. The scoreboard compares each presented address against the order the requirements predict. Separate checks sample the valid flag at the exact cycles that the latency and hold rules fix.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

    // Vector address reserved for the non-maskable reset request
    localparam int unsigned RESET_VECTOR = 0;

    // Source of the next global-enable update, highest precedence first
    typedef enum logic [1:0] {
        GIE_KEEP  = 2'd0,
        GIE_TAKEN = 2'd1,
        GIE_WRITE = 2'd2,
        GIE_RET   = 2'd3
    } gie_cause_e;

    // Interrupt line index -> vector address
    function automatic int unsigned line_vector(input int unsigned idx);
        return idx + 1;
    endfunction

    function automatic gie_cause_e gie_cause(input logic taken,
                                             input logic wr,
                                             input logic ret);
        if (taken)    return GIE_TAKEN;
        else if (wr)  return GIE_WRITE;
        else if (ret) return GIE_RET;
        else          return GIE_KEEP;
    endfunction

endpackage

// File: rtl/vpic_pending.sv
module vpic_pending #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] pend_o
);

    for (genvar k = 0; k < WIDTH; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                pend_o[k] <= 1'b0;
            else
                pend_o[k] <= (pend_o[k] & ~clr_i[k]) | set_i[k];
        end
    end

endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter
    import vpic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    localparam int unsigned VEC_W  = $clog2(NUM_SRC + 1)
) (
    input  logic               rst_pend_i,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               gie_i,
    input  logic               busy_i,
    output logic               take_rst_o,
    output logic [NUM_SRC-1:0] take_irq_o,
    output logic               take_o,
    output logic [VEC_W-1:0]   take_vec_o
);

    logic [NUM_SRC-1:0] eligible;
    logic [NUM_SRC:0]   blocked;
    logic [NUM_SRC-1:0] winner;

    assign eligible   = pend_i & en_i & {NUM_SRC{gie_i}};
    assign blocked[0] = 1'b0;

    // Lowest index outranks all higher ones
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_chain
        assign winner[k]    = eligible[k] & ~blocked[k];
        assign blocked[k+1] = blocked[k] | eligible[k];
    end

    assign take_rst_o = rst_pend_i & ~busy_i;
    assign take_irq_o = winner & {NUM_SRC{~busy_i & ~rst_pend_i}};
    assign take_o     = take_rst_o | (|take_irq_o);

    always_comb begin
        take_vec_o = VEC_W'(RESET_VECTOR);
        for (int unsigned k = 0; k < NUM_SRC; k++) begin
            if (take_irq_o[k])
                take_vec_o = VEC_W'(line_vector(k));
        end
    end

endmodule

// File: rtl/vpic_gie.sv
module vpic_gie
    import vpic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic taken_i,
    input  logic wr_i,
    input  logic wdata_i,
    input  logic ret_i,
    output logic gie_o
);

    gie_cause_e cause;

    assign cause = gie_cause(taken_i, wr_i, ret_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            gie_o <= 1'b0;
        end else begin
            unique case (cause)
                GIE_TAKEN: gie_o <= 1'b0;
                GIE_WRITE: gie_o <= wdata_i;
                GIE_RET:   gie_o <= 1'b1;
                default:   gie_o <= gie_o;
            endcase
        end
    end

endmodule

// File: rtl/vpic_vecreg.sv
module vpic_vecreg #(
    parameter int unsigned VEC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic             ack_i,
    output logic             valid_o,
    output logic [VEC_W-1:0] vec_o
);

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] addr;
    } slot_t;

    slot_t slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (load_i) begin
            slot_q.valid <= 1'b1;
            slot_q.addr  <= vec_i;
        end else if (slot_q.valid && ack_i) begin
            slot_q.valid <= 1'b0;
        end
    end

    assign valid_o = slot_q.valid;
    assign vec_o   = slot_q.addr;

endmodule

// File: rtl/vpic_top.sv
module vpic_top #(
    parameter int unsigned NUM_SRC = 8,
    localparam int unsigned VEC_W  = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reset_req,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic               gie_wr,
    input  logic               gie_wdata,
    input  logic               ret_strobe,
    input  logic               vec_ack,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_addr,
    output logic               gie
);

    logic [NUM_SRC-1:0] irq_pend;
    logic [NUM_SRC-1:0] take_irq;
    logic               rst_pend;
    logic               take_rst;
    logic               take;
    logic [VEC_W-1:0]   take_vec;

    vpic_pending #(.WIDTH(NUM_SRC)) u_irq_pend (
        .clk    (clk),
        .rst    (rst),
        .set_i  (irq_req),
        .clr_i  (take_irq),
        .pend_o (irq_pend)
    );

    vpic_pending #(.WIDTH(1)) u_rst_pend (
        .clk    (clk),
        .rst    (rst),
        .set_i  (reset_req),
        .clr_i  (take_rst),
        .pend_o (rst_pend)
    );

    vpic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .rst_pend_i (rst_pend),
        .pend_i     (irq_pend),
        .en_i       (irq_en),
        .gie_i      (gie),
        .busy_i     (vec_valid),
        .take_rst_o (take_rst),
        .take_irq_o (take_irq),
        .take_o     (take),
        .take_vec_o (take_vec)
    );

    vpic_gie u_gie (
        .clk     (clk),
        .rst     (rst),
        .taken_i (take),
        .wr_i    (gie_wr),
        .wdata_i (gie_wdata),
        .ret_i   (ret_strobe),
        .gie_o   (gie)
    );

    vpic_vecreg #(.VEC_W(VEC_W)) u_vec (
        .clk     (clk),
        .rst     (rst),
        .load_i  (take),
        .vec_i   (take_vec),
        .ack_i   (vec_ack),
        .valid_o (vec_valid),
        .vec_o   (vec_addr)
    );

endmodule

// File: rtl/vpic_checker.sv
module vpic_checker #(
    parameter int unsigned NUM_SRC = 8,
    localparam int unsigned VEC_W  = $clog2(NUM_SRC + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               gie_wr,
    input logic               gie_wdata,
    input logic               ret_strobe,
    input logic               vec_ack,
    input logic               vec_valid,
    input logic [VEC_W-1:0]   vec_addr,
    input logic               gie
);

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (vec_addr <= VEC_W'(NUM_SRC)));                       // R2

    AST_LINE_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
        ($rose(vec_valid) && vec_addr != '0) |-> $past(gie));               // R4

    AST_GIE_OFF_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_valid) |-> !gie);                                         // R6

    AST_RET_SETS_GIE: assert property (@(posedge clk) disable iff (rst)
        (ret_strobe && !gie_wr && vec_valid) |=> gie);                      // R7

    AST_WR_LOADS_GIE: assert property (@(posedge clk) disable iff (rst)
        (gie_wr && vec_valid) |=> (gie == $past(gie_wdata)));               // R7

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !vec_ack) |=> (vec_valid && $stable(vec_addr)));      // R9

    AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && vec_ack) |=> !vec_valid);                             // R9

endmodule

bind vpic_top vpic_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .gie_wr     (gie_wr),
    .gie_wdata  (gie_wdata),
    .ret_strobe (ret_strobe),
    .vec_ack    (vec_ack),
    .vec_valid  (vec_valid),
    .vec_addr   (vec_addr),
    .gie        (gie)
);

// File: tb/sim_vpic_top.sv
`timescale 1ns/1ps
module sim_vpic_top;

    localparam int unsigned N  = 8;
    localparam int unsigned VW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst;
    logic          reset_req;
    logic [N-1:0]  irq_req;
    logic [N-1:0]  irq_en;
    logic          gie_wr;
    logic          gie_wdata;
    logic          ret_strobe;
    logic          vec_ack;
    logic          vec_valid;
    logic [VW-1:0] vec_addr;
    logic          gie;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int unsigned exp_q[$];

    always #4 clk = ~clk;

    vpic_top #(.NUM_SRC(N)) u0 (
        .clk(clk), .rst(rst), .reset_req(reset_req), .irq_req(irq_req),
        .irq_en(irq_en), .gie_wr(gie_wr), .gie_wdata(gie_wdata),
        .ret_strobe(ret_strobe), .vec_ack(vec_ack), .vec_valid(vec_valid),
        .vec_addr(vec_addr), .gie(gie)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_vec(input int unsigned v);
        exp_q.push_back(v);
    endtask

    // Scoreboard monitor: compare each newly presented vector with the queue
    bit seen = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            seen <= 1'b0;
        end else if (vec_valid && !seen) begin
            seen <= 1'b1;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R3 unexpected vector", int'(vec_addr), -1);
            end else begin
                int unsigned e;
                e = exp_q.pop_front();
                check(vec_addr == VW'(e), "R2/R3 vector order", int'(vec_addr), int'(e));
            end
        end else if (!vec_valid) begin
            seen <= 1'b0;
        end
    end

    task automatic pulse_irq(input logic [N-1:0] m);
        irq_req = m;
        tick();
        irq_req = '0;
    endtask

    task automatic pulse_ret();
        ret_strobe = 1'b1;
        tick();
        ret_strobe = 1'b0;
    endtask

    task automatic write_gie(input logic v);
        gie_wr    = 1'b1;
        gie_wdata = v;
        tick();
        gie_wr    = 1'b0;
    endtask

    task automatic wait_valid(input string req);
        int n = 0;
        while (!vec_valid && n < 40) begin
            tick();
            n++;
        end
        check(vec_valid, req, int'(vec_valid), 1);
    endtask

    task automatic do_ack();
        vec_ack = 1'b1;
        tick();
        vec_ack = 1'b0;
        check(!vec_valid, "R9 drop after ack", int'(vec_valid), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] held;
        rst = 1'b1; reset_req = 1'b0; irq_req = '0; irq_en = '1;
        gie_wr = 1'b0; gie_wdata = 1'b0; ret_strobe = 1'b0; vec_ack = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check(!vec_valid, "R1 valid after reset", int'(vec_valid), 0);
        check(!gie, "R1 gie after reset", int'(gie), 0);

        // R4: masked by gie, R8: taken once allowed
        pulse_irq(8'h04);
        repeat (4) tick();
        check(!vec_valid, "R4 no take while gie=0", int'(vec_valid), 0);
        expect_vec(3);
        write_gie(1'b1);
        wait_valid("R8 pending taken after gie set");
        check(!gie, "R6 gie cleared on take", int'(gie), 0);
        held = vec_addr;
        for (int i = 0; i < 3; i++) begin
            tick();
            check(vec_valid && vec_addr == held, "R9 hold until ack", int'(vec_addr), int'(held));
        end
        do_ack();
        pulse_ret();
        check(gie, "R7 ret sets gie", int'(gie), 1);

        // R3 priority ordering
        write_gie(1'b0);
        check(!gie, "R7 gie write 0", int'(gie), 0);
        pulse_irq(8'h4A);
        expect_vec(2); expect_vec(4); expect_vec(7);
        for (int i = 0; i < 3; i++) begin
            pulse_ret();
            wait_valid("R3 next in order");
            do_ack();
        end

        // R4 per-line enable, R8 later taken
        irq_en = 8'hFE;
        pulse_ret();
        expect_vec(6);
        pulse_irq(8'h21);
        wait_valid("R4 enabled line taken");
        do_ack();
        pulse_ret();
        repeat (4) tick();
        check(!vec_valid, "R4 disabled line held off", int'(vec_valid), 0);
        expect_vec(1);
        irq_en = '1;
        wait_valid("R8 line taken after enable");
        do_ack();

        // R5 reset request ignores gie and outranks lines
        check(!gie, "R6 gie still 0", int'(gie), 0);
        expect_vec(0);
        reset_req = 1'b1; tick(); reset_req = 1'b0;
        wait_valid("R5 reset taken with gie=0");
        do_ack();
        pulse_ret();
        expect_vec(0); expect_vec(1);
        reset_req = 1'b1; irq_req = 8'h01; tick(); reset_req = 1'b0; irq_req = '0;
        wait_valid("R5 reset first");
        do_ack();
        pulse_ret();
        wait_valid("R5 line after reset");
        do_ack();

        // R10 latency
        pulse_ret();
        expect_vec(4);
        irq_req = 8'h08;
        tick();
        irq_req = '0;
        check(!vec_valid, "R10 not yet valid", int'(vec_valid), 0);
        tick();
        check(vec_valid, "R10 valid at second edge", int'(vec_valid), 1);
        do_ack();

        repeat (3) tick();
        check(exp_q.size() == 0, "R3 all expected vectors seen", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule